// File: doc/BRIEF.md
# Sync Word Detector and Payload Assembler

This block sits behind a bit-recovery stage and turns a stream of recovered bits into framed payload bytes. While hunting, every qualified bit enters a history register. The history is compared with a programmable synchronization pattern of 1 to 32 bits, and only the low `sync_len` bits of the pattern and of the history take part in the comparison. Once the pattern is seen, the block stops hunting and packs the following bits into bytes, most significant bit first, until the programmed number of bytes has been collected. It then goes back to hunting.

During collection each byte is checked against a reference payload that is held in a small register array. The array is loaded from a parameter at reset. If every byte matches, a packet-good flag is raised for a fixed number of clock cycles. A level output shows that a frame is in progress, from the bit that completes the sync pattern to the last payload byte.

Top module: `sync_payload_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `byte_vld`, `sync_flag` and `pkt_ok` are low.
- R2: `sync_flag` rises in the cycle after the bit that makes the last `sync_len` hunted bits equal to the low `sync_len` bits of `sync_word`, with the oldest bit compared against bit `sync_len-1`. Pattern bits at and above `sync_len` are ignored. A `sync_len` of 0 counts as 1 and a value above 32 counts as 32.
- R3: A match needs at least `sync_len` qualified bits since hunting began, that is, since reset or the previous match. Older history and zero fill never complete a match.
- R4: A cycle with `bit_vld` low changes no state: `sync_flag` holds and `byte_vld` stays low.
- R5: Payload bits fill a byte MSB first. `byte_vld` is high for exactly one cycle, the cycle after every eighth payload bit, and `byte_data` then carries the byte.
- R6: `sync_flag` stays high for the whole payload and falls together with the `byte_vld` of the last byte. Payload bits are never compared with the sync pattern, so a payload that contains the pattern does not restart the frame.
- R7: If all payload bytes equal the reference, `pkt_ok` rises together with the last `byte_vld` and stays high for exactly `HOLD_CYC` cycles.
- R8: A mismatch in any payload byte keeps `pkt_ok` low for that packet.
- R9: A `pay_len` of 0 collects one byte. A `pay_len` above `MAX_BYTES` collects `MAX_BYTES` bytes.
- R10: A good packet that ends while `pkt_ok` is still high restarts the hold, so `pkt_ok` then stays high for `HOLD_CYC` further cycles.
- R11: After a packet ends, hunting starts from empty history, so a pattern has to be received again in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_val` in this cycle |
| bit_val | input | 1 | Recovered bit |
| sync_word | input | SYNC_W | Sync pattern, right-aligned; the oldest bit is at position `sync_len-1` |
| sync_len | input | $clog2(SYNC_W+1) | Sync pattern length in bits |
| pay_len | input | $clog2(MAX_BYTES+1) | Payload length in bytes |
| byte_vld | output | 1 | One-cycle strobe for a finished payload byte |
| byte_data | output | 8 | Finished payload byte |
| sync_flag | output | 1 | High while a frame is being collected |
| pkt_ok | output | 1 | Packet-good flag, held for `HOLD_CYC` cycles |

## Verification
The bench builds the block with `SYNC_W=32`, `MAX_BYTES=8`, the default eight-byte reference `01 23 45 67 89 AB CD EF` and `HOLD_CYC=12`. With a 32-bit pattern width, both a full-width pattern and a short pattern whose unused upper bits are non-zero can be tested. With eight bytes, both the length clamp and a packet that covers the whole reference array can be tested. A hold of 12 cycles is longer than a 2-bit-sync, one-byte packet, so a second good packet can finish inside the hold window and show that the hold restarts.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic {
        HUNT    = 1'b0,
        COLLECT = 1'b1
    } rx_mode_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } byte_beat_t;

    // Clamp a requested length into 1..max.
    function automatic int clamp_len(input int req, input int max);
        if (req <= 0)
            return 1;
        else if (req > max)
            return max;
        else
            return req;
    endfunction

endpackage

// File: rtl/rxp_sync_hunter.sv
module rxp_sync_hunter
    import rxp_pkg::*;
#(
    parameter  int W  = 32,
    localparam int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          bit_in,
    input  logic [W-1:0]  pattern,
    input  logic [LW-1:0] len,
    output logic          hit
);

    logic [W-1:0]  hist_q, hist_d, mask;
    logic [LW-1:0] fill_q, fill_d, len_eff;

    always_comb begin
        len_eff = LW'(clamp_len(int'(len), W));
        mask    = {W{1'b1}} >> (W - int'(len_eff));
        hist_d  = {hist_q[W-2:0], bit_in};
        fill_d  = (int'(fill_q) < W) ? fill_q + LW'(1) : fill_q;
        hit     = shift_en && (fill_d >= len_eff)
                  && (((hist_d ^ pattern) & mask) == '0);
    end

    // A match empties the history so the next hunt starts fresh.
    always_ff @(posedge clk) begin
        if (rst || hit) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_d;
            fill_q <= fill_d;
        end
    end

endmodule

// File: rtl/rxp_byte_packer.sv
module rxp_byte_packer
    import rxp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       take,
    input  logic       bit_in,
    output logic       done,
    output logic [7:0] word,
    output byte_beat_t beat_q
);

    logic [2:0] cnt_q;
    logic [6:0] sh_q;

    assign word = {sh_q, bit_in};
    assign done = take && (cnt_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            beat_q <= '0;
        end else begin
            beat_q.vld <= done;
            if (done)
                beat_q.data <= word;
            if (start)
                cnt_q <= '0;
            else if (take) begin
                cnt_q <= cnt_q + 3'd1;
                sh_q  <= word[6:0];
            end
        end
    end

endmodule

// File: rtl/rxp_payload_judge.sv
module rxp_payload_judge #(
    parameter  int                     MAX_BYTES = 8,
    parameter  int                     HOLD_CYC  = 1000,
    parameter  logic [MAX_BYTES*8-1:0] EXPECT    = '0,
    localparam int                     IW        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int                     HW        = $clog2(HOLD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          byte_done,
    input  logic [7:0]    byte_in,
    input  logic [IW-1:0] idx,
    input  logic          last,
    output logic          pkt_ok
);

    logic [7:0]    ref_q [MAX_BYTES];
    logic          good_q;
    logic          byte_match;
    logic [HW-1:0] hold_q;

    // Reference bytes: index 0 sits at the top of EXPECT.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_ref
        always_ff @(posedge clk) begin
            if (rst)
                ref_q[g] <= EXPECT[(MAX_BYTES-g)*8-1 -: 8];
        end
    end

    assign byte_match = (byte_in == ref_q[idx]);
    assign pkt_ok     = (hold_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (start)
                good_q <= 1'b1;
            else if (byte_done)
                good_q <= good_q && byte_match;

            if (byte_done && last && good_q && byte_match)
                hold_q <= HW'(HOLD_CYC);
            else if (hold_q != '0)
                hold_q <= hold_q - HW'(1);
        end
    end

endmodule

// File: rtl/sync_payload_rx.sv
module sync_payload_rx
    import rxp_pkg::*;
#(
    parameter  int                     SYNC_W    = 32,
    parameter  int                     MAX_BYTES = 8,
    parameter  int                     HOLD_CYC  = 1000,
    parameter  logic [MAX_BYTES*8-1:0] EXPECT    = 64'h0123456789ABCDEF,
    localparam int                     SLW       = $clog2(SYNC_W + 1),
    localparam int                     PLW       = $clog2(MAX_BYTES + 1),
    localparam int                     IW        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SLW-1:0]    sync_len,
    input  logic [PLW-1:0]    pay_len,
    output logic              byte_vld,
    output logic [7:0]        byte_data,
    output logic              sync_flag,
    output logic              pkt_ok
);

    rx_mode_e      mode_q;
    logic [IW-1:0] idx_q;
    logic          hunt_en, take, hit, done, last;
    logic [7:0]    word;
    byte_beat_t    beat_q;

    assign hunt_en = bit_vld && (mode_q == HUNT);
    assign take    = bit_vld && (mode_q == COLLECT);
    assign last    = (int'(idx_q) + 1 >= clamp_len(int'(pay_len), MAX_BYTES));

    rxp_sync_hunter #(.W(SYNC_W)) u_hunt (
        .clk      (clk),
        .rst      (rst),
        .shift_en (hunt_en),
        .bit_in   (bit_val),
        .pattern  (sync_word),
        .len      (sync_len),
        .hit      (hit)
    );

    rxp_byte_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .start  (hit),
        .take   (take),
        .bit_in (bit_val),
        .done   (done),
        .word   (word),
        .beat_q (beat_q)
    );

    rxp_payload_judge #(
        .MAX_BYTES (MAX_BYTES),
        .HOLD_CYC  (HOLD_CYC),
        .EXPECT    (EXPECT)
    ) u_judge (
        .clk       (clk),
        .rst       (rst),
        .start     (hit),
        .byte_done (done),
        .byte_in   (word),
        .idx       (idx_q),
        .last      (last),
        .pkt_ok    (pkt_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= HUNT;
            idx_q  <= '0;
        end else if (hit) begin
            mode_q <= COLLECT;
            idx_q  <= '0;
        end else if (done) begin
            if (last)
                mode_q <= HUNT;
            idx_q <= idx_q + IW'(1);
        end
    end

    assign sync_flag = (mode_q == COLLECT);
    assign byte_vld  = beat_q.vld;
    assign byte_data = beat_q.data;

endmodule

// File: rtl/rxp_checker.sv
module rxp_checker (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic byte_vld,
    input logic sync_flag,
    input logic pkt_ok
);

    // R2
    sync_rise_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_flag) |-> $past(bit_vld));

    // R4
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_vld) |-> ($stable(sync_flag) && !byte_vld));

    // R5
    byte_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(bit_vld));

    // R6
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(sync_flag));

    // R6
    frame_end_byte_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_flag) |-> byte_vld);

    // R7
    ok_at_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_ok) |-> $fell(sync_flag));

endmodule

bind sync_payload_rx rxp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .byte_vld  (byte_vld),
    .sync_flag (sync_flag),
    .pkt_ok    (pkt_ok)
);

// File: tb/tb_sync_payload_rx.sv
module tb_sync_payload_rx;

    localparam int SYNC_W    = 32;
    localparam int MAX_BYTES = 8;
    localparam int HOLD_CYC  = 12;

    typedef struct packed {
        logic [31:0] sw;
        logic [5:0]  sl;
        logic [3:0]  pl;
        logic [63:0] pay;
        logic        ok;
    } vec_t;

    // R2 R5 R6 R7 R8 R9 exercised by this table
    localparam vec_t VECS [8] = '{
        '{32'h00AA2DD4, 6'd24, 4'd5,  64'h0123456789000000, 1'b1},
        '{32'h00AA2DD4, 6'd24, 4'd5,  64'h0123456788000000, 1'b0},
        '{32'h12345678, 6'd32, 4'd8,  64'h0123456789ABCDEF, 1'b1},
        '{32'hFFFF00B4, 6'd8,  4'd2,  64'h0123000000000000, 1'b1},
        '{32'h000000C3, 6'd8,  4'd0,  64'h0100000000000000, 1'b1},
        '{32'h000000C3, 6'd8,  4'd15, 64'h0123456789ABCDEF, 1'b1},
        '{32'h0000002D, 6'd8,  4'd3,  64'h2D2D2D0000000000, 1'b0},
        '{32'h00000A5A, 6'd12, 4'd5,  64'h0023456789000000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_vld;
    logic        bit_val;
    logic [31:0] sync_word;
    logic [5:0]  sync_len;
    logic [3:0]  pay_len;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        sync_flag;
    logic        pkt_ok;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    sync_payload_rx #(
        .SYNC_W    (SYNC_W),
        .MAX_BYTES (MAX_BYTES),
        .HOLD_CYC  (HOLD_CYC)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .sync_word (sync_word),
        .sync_len  (sync_len),
        .pay_len   (pay_len),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .sync_flag (sync_flag),
        .pkt_ok    (pkt_ok)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with outputs settled.
    task automatic send_bit(input logic b);
        bit_vld = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int j = 7; j >= 0; j--) send_bit(b[j]);
    endtask

    task automatic send_sync(input logic [31:0] w, input int n);
        for (int j = n - 1; j >= 0; j--) send_bit(w[j]);
    endtask

    task automatic measure_ok(output int n);
        n = 0;
        while (pkt_ok && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int nb;
        int held;
        logic [7:0] b;
        nb = (v.pl == 0) ? 1 : ((int'(v.pl) > MAX_BYTES) ? MAX_BYTES : int'(v.pl));
        sync_word = v.sw;
        sync_len  = v.sl;
        pay_len   = v.pl;
        for (int i = int'(v.sl) - 1; i >= 1; i--) send_bit(v.sw[i]);
        check("R2 flag low before final sync bit", sync_flag, 0);
        send_bit(v.sw[0]);
        check("R2 flag high after final sync bit", sync_flag, 1);
        for (int k = 0; k < nb; k++) begin
            b = v.pay[63-8*k -: 8];
            for (int j = 7; j >= 1; j--) send_bit(b[j]);
            check("R5 no strobe mid byte", byte_vld, 0);
            send_bit(b[0]);
            check("R5 byte strobe", byte_vld, 1);
            check("R5 byte value", byte_data, b);
            check("R6 frame level", sync_flag, (k < nb - 1) ? 1 : 0);
        end
        if (v.pl == 0 || int'(v.pl) > MAX_BYTES)
            check("R9 clamped length ends frame", sync_flag, 0);
        if (v.ok) begin
            measure_ok(held);
            check("R7 valid hold length", held, HOLD_CYC);
        end else begin
            check("R8 no valid on mismatch", pkt_ok, 0);
            idle(2);
            check("R8 valid stays low", pkt_ok, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int held;
        rst = 1'b1;
        bit_vld = 1'b0;
        bit_val = 1'b0;
        sync_word = '0;
        sync_len = 6'd8;
        pay_len = 4'd1;
        idle(3);
        check("R1 strobe low in reset", byte_vld, 0);
        check("R1 frame low in reset", sync_flag, 0);
        check("R1 valid low in reset", pkt_ok, 0);
        rst = 1'b0;
        idle(1);
        check("R1 frame low after reset", sync_flag, 0);
        check("R1 valid low after reset", pkt_ok, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R3: all-zero pattern needs sync_len fresh bits
        sync_word = 32'h0; sync_len = 6'd4; pay_len = 4'd1;
        send_sync(32'h0, 3);
        check("R3 three zeros do not match", sync_flag, 0);
        send_bit(1'b0);
        check("R3 fourth zero matches", sync_flag, 1);
        send_byte(8'h01);
        check("R3 frame closes", sync_flag, 0);
        measure_ok(held);
        check("R3 packet good", held, HOLD_CYC);

        // R4: idle cycles between payload bits
        sync_word = 32'hC3; sync_len = 6'd8; pay_len = 4'd1;
        send_sync(32'hC3, 8);
        for (int j = 7; j >= 1; j--) begin
            send_bit(8'h01 >> j);
            idle(3);
        end
        check("R4 frame held over gaps", sync_flag, 1);
        check("R4 no strobe over gaps", byte_vld, 0);
        send_bit(1'b1);
        check("R4 byte strobe after gaps", byte_vld, 1);
        check("R4 byte value after gaps", byte_data, 8'h01);
        idle(1);
        check("R5 strobe one cycle only", byte_vld, 0);
        measure_ok(held);
        check("R4 packet good after gaps", held, HOLD_CYC - 1);

        // R10: second good packet inside the hold window
        sync_word = 32'h3; sync_len = 6'd2; pay_len = 4'd1;
        send_sync(32'h3, 2);
        send_byte(8'h01);
        check("R10 first packet good", pkt_ok, 1);
        send_sync(32'h3, 2);
        send_byte(8'h01);
        check("R10 valid still high", pkt_ok, 1);
        measure_ok(held);
        check("R10 hold restarted", held, HOLD_CYC);

        // R11: history empty after a packet
        sync_word = 32'h5; sync_len = 6'd3; pay_len = 4'd1;
        send_sync(32'h5, 3);
        send_byte(8'h01);
        send_bit(1'b0);
        send_bit(1'b1);
        check("R11 no match from old history", sync_flag, 0);
        idle(HOLD_CYC);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        send_sync(32'h5, 3);
        check("R11 full pattern matches", sync_flag, 1);
        send_byte(8'h01);
        check("R11 frame closes", sync_flag, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule